// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block programs a slave-serial FPGA from a stream of image bytes. After a start request it pulls the active-low program line low for a fixed number of system clocks and then releases it. It waits for the target's active-low init line to return high. It then shifts the requested number of bytes out on a serial data pin, most significant bit first, with one configuration-clock pulse per bit. Once the image is in, it keeps pulsing the configuration clock until the target raises done. Both wait points are bounded, and each one reports its own timeout flag.

The image bytes arrive over a valid/ready stream. A byte moves when `s_valid` and `s_ready` are both high on a rising clock edge. The source must hold `s_data` and `s_err` steady while `s_valid` is high and `s_ready` is low. The block raises `s_ready` only while it is in the shift phase with its shifter empty, so back-pressure lasts for the whole serialisation of each byte. A beat with `s_err` high marks a stream fault. That beat is not shifted, shifting stops, and the block goes straight to post-load clocking.

The block remembers which image identifier was last loaded with success. A start request for that same identifier does nothing on the configuration pins and reports success at once. The init and done inputs pass through a synchronizer before any decision uses them. `PROG_HOLD_CYC` must therefore exceed the synchronizer depth.

Top module: `fpga_cfg_loader`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `cfg_prog_n` is 1, `cfg_clk` is 0, `cfg_dout` is 0 and `s_ready` is 0. All three status flags are 0 after reset.
- R2: A load drives `cfg_prog_n` low for exactly `PROG_HOLD_CYC` clock cycles and then high. No `cfg_clk` pulse occurs while it is low.
- R3: After program is released, init (`cfg_init_n`) is polled once per cycle for at most `INIT_POLL_MAX` cycles. If it never reads high, the load ends with `err_init_to` set, no byte accepted and no configuration clock issued. The total busy time is then `PROG_HOLD_CYC + INIT_POLL_MAX` cycles.
- R4: Each byte leaves MSB first, one bit per rising `cfg_clk` edge. `cfg_dout` changes only while `cfg_clk` is 0. The high and the low phase of `cfg_clk` each last at least `PHASE_CYC` cycles, and the high phase lasts exactly `PHASE_CYC` cycles.
- R5: Exactly `img_len` bytes are shifted. A length of 0 shifts none. An accepted beat with `s_err`=1 is not shifted and ends shifting at once.
- R6: After shifting, single `cfg_clk` pulses repeat until the synchronized done input is high, and then `load_ok` is set. If done does not rise within `DONE_PULSE_MAX` pulses, exactly that many are issued and `err_done_to` is set.
- R7: A start whose `img_id` equals the identifier of the last successful load causes no pin activity and no busy time, and sets `load_ok` one cycle later. A failed load forgets the remembered identifier.
- R8: `s_ready` is high only in the shift phase with the shifter empty. A byte held on the stream under back-pressure, or sent after idle gaps, is shifted unchanged.
- R9: A start request while `busy` is high is ignored: no new program pulse, and the identifier recorded on success is the one from the accepted start.
- R10: At most one of `load_ok`, `err_init_to` and `err_done_to` is high at a time. All three are low while busy. A flag holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle load request, sampled when idle |
| img_id | input | ID_W | Identifier of the requested image |
| img_len | input | LEN_W | Number of image bytes to shift |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted this cycle when valid |
| s_data | input | BYTE_W | Stream byte |
| s_err | input | 1 | Stream fault marker on a beat |
| cfg_prog_n | output | 1 | Active-low program line to the FPGA |
| cfg_clk | output | 1 | Configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| cfg_init_n | input | 1 | Active-low init line from the FPGA |
| cfg_done | input | 1 | Done line from the FPGA |
| busy | output | 1 | Load sequence in progress |
| load_ok | output | 1 | Last request ended with done high, or was skipped |
| err_init_to | output | 1 | Init never released within the poll limit |
| err_done_to | output | 1 | Done never rose within the pulse limit |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a load. A second case is the check that the identifier recorded afterwards is the accepted one, which only a later skipped request can reveal. The bench starts image 5, pushes two bytes, and then pulses start for image 6 with a different length. It finishes image 5 and requests 5 again, so the missing program pulse shows which identifier was stored. The done timeout is reached through a target model that never raises done. The bench then shows that a reload of the same identifier is not skipped.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_SHIFT,
    ST_CLOCKOUT
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fpga_cfg_sync.sv
module fpga_cfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/fpga_cfg_shifter.sv
module fpga_cfg_shifter #(
  parameter int BYTE_W    = 8,
  parameter int PHASE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_go,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              pulse_go,
  output logic              idle,
  output logic              cclk,
  output logic              cdata
);

  localparam int PH_W  = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int BIT_W = $clog2(BYTE_W + 1);

  logic              active;
  logic              high;
  logic [PH_W-1:0]   ph_cnt;
  logic [BIT_W-1:0]  bits_left;
  logic [BYTE_W-1:0] sreg;

  assign idle = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      high      <= 1'b0;
      ph_cnt    <= '0;
      bits_left <= '0;
      sreg      <= '0;
      cclk      <= 1'b0;
      cdata     <= 1'b0;
    end else if (!active) begin
      if (byte_go) begin
        active    <= 1'b1;
        high      <= 1'b0;
        ph_cnt    <= '0;
        bits_left <= BIT_W'(BYTE_W);
        sreg      <= byte_in;
        cdata     <= byte_in[BYTE_W-1];
      end else if (pulse_go) begin
        active    <= 1'b1;
        high      <= 1'b0;
        ph_cnt    <= '0;
        bits_left <= BIT_W'(1);
        sreg      <= '0;
        cdata     <= 1'b0;
      end
    end else if (ph_cnt == PH_W'(PHASE_CYC - 1)) begin
      ph_cnt <= '0;
      if (!high) begin
        high <= 1'b1;
        cclk <= 1'b1;
      end else begin
        high <= 1'b0;
        cclk <= 1'b0;
        if (bits_left == BIT_W'(1)) begin
          active <= 1'b0;
          cdata  <= 1'b0;
        end else begin
          bits_left <= bits_left - 1'b1;
          sreg      <= sreg << 1;
          cdata     <= sreg[BYTE_W-2];
        end
      end
    end else begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_pkg::*;
#(
  parameter int LEN_W          = 32,
  parameter int ID_W           = 4,
  parameter int PROG_HOLD_CYC  = 64,
  parameter int INIT_POLL_MAX  = 100000,
  parameter int DONE_PULSE_MAX = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  img_id,
  input  logic [LEN_W-1:0] img_len,
  input  logic             s_valid,
  input  logic             s_err,
  output logic             s_ready,
  input  logic             init_ok,
  input  logic             done_ok,
  input  logic             sh_idle,
  output logic             byte_go,
  output logic             pulse_go,
  output logic             prog_n,
  output logic             busy,
  output logic             load_ok,
  output logic             err_init_to,
  output logic             err_done_to
);

  localparam int CNT_MAX = max3(PROG_HOLD_CYC, INIT_POLL_MAX, DONE_PULSE_MAX);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] len_left;
  logic [ID_W-1:0]  req_id;
  logic [ID_W-1:0]  loaded_id;
  logic             loaded_vld;
  logic             accept;

  assign busy     = (state != ST_IDLE);
  assign prog_n   = (state != ST_PROG);
  assign s_ready  = (state == ST_SHIFT) && sh_idle && (len_left != '0);
  assign accept   = s_valid && s_ready;
  assign byte_go  = accept && !s_err;
  assign pulse_go = (state == ST_CLOCKOUT) && sh_idle && !done_ok &&
                    (cnt != CNT_W'(DONE_PULSE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      len_left    <= '0;
      req_id      <= '0;
      loaded_id   <= '0;
      loaded_vld  <= 1'b0;
      load_ok     <= 1'b0;
      err_init_to <= 1'b0;
      err_done_to <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            err_init_to <= 1'b0;
            err_done_to <= 1'b0;
            if (loaded_vld && (img_id == loaded_id)) begin
              load_ok <= 1'b1;
            end else begin
              load_ok    <= 1'b0;
              loaded_vld <= 1'b0;
              req_id     <= img_id;
              len_left   <= img_len;
              cnt        <= '0;
              state      <= ST_PROG;
            end
          end
        end
        ST_PROG: begin
          if (cnt == CNT_W'(PROG_HOLD_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_WAIT_INIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT_INIT: begin
          if (init_ok) begin
            cnt   <= '0;
            state <= (len_left == '0) ? ST_CLOCKOUT : ST_SHIFT;
          end else if (cnt == CNT_W'(INIT_POLL_MAX - 1)) begin
            err_init_to <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (accept) begin
            if (s_err) begin
              state <= ST_CLOCKOUT;
            end else begin
              len_left <= len_left - 1'b1;
              if (len_left == LEN_W'(1)) state <= ST_CLOCKOUT;
            end
          end
        end
        ST_CLOCKOUT: begin
          if (sh_idle) begin
            if (done_ok) begin
              load_ok    <= 1'b1;
              loaded_vld <= 1'b1;
              loaded_id  <= req_id;
              state      <= ST_IDLE;
            end else if (cnt == CNT_W'(DONE_PULSE_MAX)) begin
              err_done_to <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int BYTE_W         = 8,
  parameter int LEN_W          = 32,
  parameter int ID_W           = 4,
  parameter int PROG_HOLD_CYC  = 64,
  parameter int INIT_POLL_MAX  = 100000,
  parameter int DONE_PULSE_MAX = 100000,
  parameter int PHASE_CYC      = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ID_W-1:0]   img_id,
  input  logic [LEN_W-1:0]  img_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_err,
  output logic              cfg_prog_n,
  output logic              cfg_clk,
  output logic              cfg_dout,
  input  logic              cfg_init_n,
  input  logic              cfg_done,
  output logic              busy,
  output logic              load_ok,
  output logic              err_init_to,
  output logic              err_done_to
);

  logic [1:0] sync_q;
  logic       sh_idle;
  logic       byte_go;
  logic       pulse_go;

  fpga_cfg_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_done, cfg_init_n}),
    .q     (sync_q)
  );

  fpga_cfg_seq #(
    .LEN_W          (LEN_W),
    .ID_W           (ID_W),
    .PROG_HOLD_CYC  (PROG_HOLD_CYC),
    .INIT_POLL_MAX  (INIT_POLL_MAX),
    .DONE_PULSE_MAX (DONE_PULSE_MAX)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .img_id      (img_id),
    .img_len     (img_len),
    .s_valid     (s_valid),
    .s_err       (s_err),
    .s_ready     (s_ready),
    .init_ok     (sync_q[0]),
    .done_ok     (sync_q[1]),
    .sh_idle     (sh_idle),
    .byte_go     (byte_go),
    .pulse_go    (pulse_go),
    .prog_n      (cfg_prog_n),
    .busy        (busy),
    .load_ok     (load_ok),
    .err_init_to (err_init_to),
    .err_done_to (err_done_to)
  );

  fpga_cfg_shifter #(
    .BYTE_W    (BYTE_W),
    .PHASE_CYC (PHASE_CYC)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_go  (byte_go),
    .byte_in  (s_data),
    .pulse_go (pulse_go),
    .idle     (sh_idle),
    .cclk     (cfg_clk),
    .cdata    (cfg_dout)
  );

endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic s_ready,
  input logic cfg_prog_n,
  input logic cfg_clk,
  input logic cfg_dout,
  input logic busy,
  input logic load_ok,
  input logic err_init_to,
  input logic err_done_to
);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cfg_prog_n && !cfg_clk && !cfg_dout && !s_ready)); // R1

  AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (!cfg_clk && !s_ready)); // R2

  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cfg_dout) |-> !cfg_clk); // R4

  AST_READY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && cfg_prog_n)); // R8

  AST_END_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (load_ok || err_init_to || err_done_to)); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ok, err_init_to, err_done_to})); // R10

  AST_FLAGS_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(load_ok || err_init_to || err_done_to)); // R10

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |->
      $stable({load_ok, err_init_to, err_done_to})); // R10

endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .s_ready     (s_ready),
  .cfg_prog_n  (cfg_prog_n),
  .cfg_clk     (cfg_clk),
  .cfg_dout    (cfg_dout),
  .busy        (busy),
  .load_ok     (load_ok),
  .err_init_to (err_init_to),
  .err_done_to (err_done_to)
);

// File: tb/fpga_cfg_loader_bench.sv
`timescale 1ns/1ps
module fpga_cfg_loader_bench;

  localparam int PROG  = 8;
  localparam int IPOLL = 40;
  localparam int DMAX  = 30;
  localparam int PH    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  img_id = '0;
  logic [15:0] img_len = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_err = 1'b0;
  logic        cfg_prog_n, cfg_clk, cfg_dout;
  logic        cfg_init_n = 1'b1;
  logic        cfg_done = 1'b0;
  logic        busy, load_ok, err_init_to, err_done_to;

  always #4 clk = ~clk;

  fpga_cfg_loader #(
    .BYTE_W(8), .LEN_W(16), .ID_W(4), .PROG_HOLD_CYC(PROG),
    .INIT_POLL_MAX(IPOLL), .DONE_PULSE_MAX(DMAX), .PHASE_CYC(PH), .SYNC_STAGES(2)
  ) u_fpga_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .img_id(img_id), .img_len(img_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_err(s_err),
    .cfg_prog_n(cfg_prog_n), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout),
    .cfg_init_n(cfg_init_n), .cfg_done(cfg_done), .busy(busy), .load_ok(load_ok),
    .err_init_to(err_init_to), .err_done_to(err_done_to)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] pat [0:15];

  int init_delay = 1;
  int done_after = 1;
  int init_cnt, prog_pulses, prog_low_len, rises_in_prog, total_rises;
  int extra_pulses, bytes_seen, data_hi_changes, min_hi, min_lo;
  int ready_cycles, busy_cycles, cur_hi, cur_lo, bitcnt;
  logic [7:0] sh;
  logic prev_cclk = 1'b0, prev_prog = 1'b1, rise_data = 1'b0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // monitor, scoreboard and FPGA target model in one process
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cycles++;
      if (s_ready) ready_cycles++;
      if (!cfg_prog_n) begin
        if (prev_prog) prog_pulses++;
        prog_low_len++;
        bitcnt = 0;
      end
      if (cfg_clk && !prev_cclk) begin
        total_rises++;
        if (!cfg_prog_n) rises_in_prog++;
        if (cur_lo < min_lo) min_lo = cur_lo;
        cur_hi = 1;
        rise_data = cfg_dout;
        if (exp_q.size() > 0) begin
          sh = {sh[6:0], cfg_dout};
          bitcnt++;
          if (bitcnt == 8) begin
            logic [7:0] e;
            bitcnt = 0;
            e = exp_q.pop_front();
            chk_eq("R4 byte MSB-first", int'(sh), int'(e));
            bytes_seen++;
          end
        end else begin
          extra_pulses++;
        end
      end else if (cfg_clk) begin
        cur_hi++;
        if (cfg_dout != rise_data) data_hi_changes++;
      end else if (prev_cclk) begin
        if (cur_hi < min_hi) min_hi = cur_hi;
        cur_lo = 1;
      end else begin
        cur_lo++;
      end
      if (!cfg_prog_n) begin
        cfg_init_n = 1'b0;
        init_cnt = 0;
        cfg_done = 1'b0;
      end else begin
        if (!cfg_init_n && init_delay >= 0) begin
          init_cnt++;
          if (init_cnt >= init_delay) cfg_init_n = 1'b1;
        end
        if (!cfg_done && done_after >= 0 && cfg_init_n && exp_q.size() == 0 &&
            extra_pulses >= done_after)
          cfg_done = 1'b1;
      end
      prev_prog = cfg_prog_n;
      prev_cclk = cfg_clk;
    end
  end

  task automatic clear_mon();
    @(posedge clk); #1;
    prog_pulses = 0; prog_low_len = 0; rises_in_prog = 0; total_rises = 0;
    extra_pulses = 0; bytes_seen = 0; data_hi_changes = 0;
    min_hi = 1000; min_lo = 1000; ready_cycles = 0; busy_cycles = 0;
    cur_hi = 0; cur_lo = 1000; bitcnt = 0;
    exp_q.delete();
  endtask

  task automatic pulse_start(input logic [3:0] id, input int len);
    @(negedge clk);
    start = 1'b1; img_id = id; img_len = 16'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_beat(input logic [7:0] d, input logic e);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_err = e;
    while (!s_ready) @(negedge clk);
    if (!e) exp_q.push_back(d);
    @(negedge clk);
    s_valid = 1'b0; s_err = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) pat[i] = 8'hA5 ^ 8'(i * 37);
    pat[1] = 8'h00;
    pat[2] = 8'hFF;
    clear_mon();
    repeat (4) @(negedge clk);
    @(posedge clk); #1;
    // R1 reset state
    chk_eq("R1 reset prog_n", int'(cfg_prog_n), 1);
    chk_eq("R1 reset cclk/dout/ready", int'({cfg_clk, cfg_dout, s_ready}), 0);
    chk_eq("R1 reset busy/flags", int'({busy, load_ok, err_init_to, err_done_to}), 0);
    @(negedge clk); rst_n = 1'b1;

    // Normal load with gaps (R2 R4 R5 R6 R8)
    clear_mon();
    init_delay = 5; done_after = 4;
    pulse_start(4'd3, 5);
    for (int i = 0; i < 5; i++) begin
      send_beat(pat[i], 1'b0);
      repeat (i % 3) @(negedge clk);
    end
    wait_idle();
    chk_eq("R6 load_ok after done", int'({load_ok, err_init_to, err_done_to}), 4);
    chk_eq("R2 one program pulse", prog_pulses, 1);
    chk_eq("R2 program low length", prog_low_len, PROG);
    chk_eq("R2 no clock while program low", rises_in_prog, 0);
    chk_eq("R5 bytes shifted", bytes_seen, 5);
    chk_eq("R8 scoreboard drained", exp_q.size(), 0);
    chk_rng("R6 post-load pulses", extra_pulses, 4, 6);
    chk_eq("R4 data stable while clock high", data_hi_changes, 0);
    chk_eq("R4 high phase length", min_hi, PH);
    chk_rng("R4 low phase length", min_lo, PH, 1000);

    // R10 flag held while idle
    repeat (40) @(posedge clk); #1;
    chk_eq("R10 load_ok held", int'(load_ok), 1);

    // R7 skip of same image
    clear_mon();
    pulse_start(4'd3, 5);
    repeat (6) @(negedge clk);
    @(posedge clk); #1;
    chk_eq("R7 skip ok", int'(load_ok), 1);
    chk_eq("R7 skip no pins/busy", prog_pulses + busy_cycles + total_rises, 0);

    // R9 start while busy ignored
    clear_mon();
    init_delay = 3; done_after = 2;
    pulse_start(4'd5, 4);
    @(posedge clk); #1;
    chk_eq("R10 flags cleared at start", int'({busy, load_ok}), 2);
    send_beat(pat[5], 1'b0);
    send_beat(pat[6], 1'b0);
    pulse_start(4'd6, 2);
    send_beat(pat[7], 1'b0);
    send_beat(pat[8], 1'b0);
    wait_idle();
    chk_eq("R9 single program pulse", prog_pulses, 1);
    chk_eq("R9 all four bytes of first request", bytes_seen, 4);
    clear_mon();
    pulse_start(4'd5, 4);
    repeat (6) @(negedge clk);
    @(posedge clk); #1;
    chk_eq("R9 recorded id is the accepted one", prog_pulses * 2 + int'(load_ok), 1);

    // R3 init timeout
    clear_mon();
    init_delay = -1; done_after = 1;
    pulse_start(4'd8, 3);
    wait_idle();
    chk_eq("R3 init timeout flag", int'({load_ok, err_init_to, err_done_to}), 2);
    chk_eq("R3 busy time", busy_cycles, PROG + IPOLL);
    chk_eq("R3 no clock issued", total_rises, 0);
    chk_eq("R8 no ready without init", ready_cycles, 0);

    // R6 done timeout
    clear_mon();
    init_delay = 2; done_after = -1;
    pulse_start(4'd9, 2);
    send_beat(pat[9], 1'b0);
    send_beat(pat[10], 1'b0);
    wait_idle();
    chk_eq("R6 done timeout flag", int'({load_ok, err_init_to, err_done_to}), 1);
    chk_eq("R6 pulses before timeout", extra_pulses, DMAX);
    chk_eq("R5 bytes before done timeout", bytes_seen, 2);

    // R7 failed load is not remembered
    clear_mon();
    done_after = 3;
    pulse_start(4'd9, 1);
    send_beat(pat[11], 1'b0);
    wait_idle();
    chk_eq("R7 reload after failure", prog_pulses, 1);
    chk_eq("R7 reload ok", int'(load_ok), 1);

    // R5 stream error aborts shifting
    clear_mon();
    init_delay = 4; done_after = 2;
    pulse_start(4'd10, 6);
    for (int i = 0; i < 3; i++) send_beat(pat[12 + i], 1'b0);
    send_beat(8'h55, 1'b1);
    wait_idle();
    chk_eq("R5 bytes before stream error", bytes_seen, 3);
    chk_eq("R5 error beat not shifted", exp_q.size(), 0);
    chk_eq("R5 ok after abort", int'(load_ok), 1);

    // R5 zero length
    clear_mon();
    done_after = 1;
    pulse_start(4'd11, 0);
    wait_idle();
    chk_eq("R5 zero length shifts nothing", bytes_seen + ready_cycles, 0);
    chk_rng("R6 zero length post pulses", extra_pulses, 1, 3);
    chk_eq("R5 zero length ok", int'(load_ok), 1);

    finish_run();
  end

endmodule